// File: doc/BRIEF.md
# I/O Home-Node Error Response Steering

This block sits beside the request path of an I/O home node and decides how each request that ends at the node is treated when it is illegal there. It classifies every request by kind and by target. From that it decides two independent things: whether to send an error event to the management node, and whether the requester gets a non-data error response instead of a normal completion. It also watches the downstream write-response channel for error codes. It passes downstream read-response codes through to the requester untouched.

The two error paths are gated by separate bits of a small auxiliary control register, each with its own reset default. Request-side error events are enabled out of reset. Write-response error events are disabled out of reset. Non-data error responses for cache maintenance operations are also disabled out of reset. Software reads and writes the register through a simple one-cycle register port. All decisions are registered and appear exactly one cycle after the inputs that caused them.

Top module: `iohn_err_steer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0004: the request-error enable (bit 2) is 1, and the write-response-error enable (bit 3) and the maintenance-response enable (bit 8) are 0.
- R2: A write on `cfg_wr_en` updates only bits 2, 3 and 8 of the control register, with effect from the next cycle. Every other bit always reads 0.
- R3: A request of kind cacheable read (2), cacheable write (3) or cache maintenance (4), to any target, raises `mn_err_pulse` in the next cycle when control bit 2 is set. It raises nothing when the bit is clear.
- R4: A configuration read (5) or write (6) to the management-node target (2) with `cfg_illegal` high raises `mn_err_pulse` in the next cycle when control bit 2 is set. A legal configuration access, or one to any other target, raises nothing.
- R5: A downstream write response with code 10 (data error) or 11 (non-data error) raises `mn_err_pulse` in the next cycle when control bit 3 is set. Codes 00 (OK) and 01 (exclusive OK) never do.
- R6: A cacheable read (2) to target 1 (this node) or target 2 (management node) gets `req_rsp_code` 11 (non-data error), whatever the control bits hold.
- R7: A cache maintenance request (4) to target 1 or 2 gets `req_rsp_code` 11 only when control bit 8 is set. Otherwise it gets 00.
- R8: `req_rsp_valid` is high exactly in the cycle after each `req_valid`. Every request not covered by R6 or R7, including kinds 0, 1, 5, 6, 7 and any request to targets 0 or 3, gets code 00.
- R9: A downstream read response appears on `rd_out_valid`/`rd_out_code` one cycle later with its code unchanged, including 10 and 11.
- R10: `mn_err_pulse` is high for exactly the cycles that follow a cycle with at least one qualifying event. A request event and a write-response event in the same cycle give a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | Request kind: 0 plain read, 1 plain write, 2 cacheable read, 3 cacheable write, 4 maintenance, 5 config read, 6 config write, 7 other |
| req_tgt | input | 2 | Target: 0 downstream space, 1 this node, 2 management node, 3 treated as downstream |
| cfg_illegal | input | 1 | The configuration access breaks the access rules |
| wr_rsp_valid | input | 1 | Downstream write response valid |
| wr_rsp_code | input | 2 | Downstream write response code |
| rd_rsp_valid | input | 1 | Downstream read response valid |
| rd_rsp_code | input | 2 | Downstream read response code |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read data |
| mn_err_pulse | output | 1 | One-cycle error event to the management node |
| req_rsp_valid | output | 1 | Response decision for the previous cycle's request |
| req_rsp_code | output | 2 | Response code for the requester: 00 OK, 11 non-data error |
| rd_out_valid | output | 1 | Read response forwarded to the requester |
| rd_out_code | output | 2 | Forwarded read response code |

## Verification
A corrupted control register shows up within one cycle on `cfg_rdata`. It also shows up on the first request or write response that the affected enable gates: a missing or extra `mn_err_pulse`, or a wrong maintenance response code. A wrong classification shows up on the next cycle's pulse or response code for that request kind and target. A fault in the read path shows up on the next forwarded read code. The random mix changes the control bits while traffic is flowing. This exposes an enable that is sampled a cycle early or late.

// File: rtl/iohn_err_pkg.sv
// Package: shared encodings for the I/O home-node error steering block.
// Assumes 2-bit response codes and 3-bit request kinds on all interfaces.
package iohn_err_pkg;

    localparam int CODE_W = 2;
    localparam int KIND_W = 3;
    localparam int TGT_W  = 2;

    // Response codes
    localparam logic [CODE_W-1:0] RSP_OK     = 2'b00;
    localparam logic [CODE_W-1:0] RSP_EXOK   = 2'b01;
    localparam logic [CODE_W-1:0] RSP_DERR   = 2'b10;
    localparam logic [CODE_W-1:0] RSP_NDERR  = 2'b11;

    // Request kinds
    typedef enum logic [KIND_W-1:0] {
        K_RD_PLAIN  = 3'd0,
        K_WR_PLAIN  = 3'd1,
        K_RD_CACHE  = 3'd2,
        K_WR_CACHE  = 3'd3,
        K_MAINT     = 3'd4,
        K_CFG_RD    = 3'd5,
        K_CFG_WR    = 3'd6,
        K_OTHER     = 3'd7
    } req_kind_e;

    // Request targets
    typedef enum logic [TGT_W-1:0] {
        T_DOWN   = 2'd0,
        T_LOCAL  = 2'd1,
        T_MGMT   = 2'd2,
        T_SPARE  = 2'd3
    } req_tgt_e;

    // True when a response code marks an error (data or non-data)
    function automatic logic code_is_err(input logic [CODE_W-1:0] c);
        return c[CODE_W-1];
    endfunction

endpackage

// File: rtl/iohn_aux_regs.sv
// Auxiliary control register for the error steering block.
// Holds the enable bits; only bits flagged in WR_MASK can ever be 1.
// Assumes a single-cycle write strobe; read data is combinational.
module iohn_aux_regs #(
    parameter int              AUX_W     = 16,
    parameter logic [AUX_W-1:0] WR_MASK  = 16'h010C,
    parameter logic [AUX_W-1:0] RST_VAL  = 16'h0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AUX_W-1:0] wdata,
    output logic [AUX_W-1:0] rdata
);
    logic [AUX_W-1:0] aux_q;

    // Hold the control bits; non-writable bits are forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= RST_VAL & WR_MASK;
        end else if (wr_en) begin
            aux_q <= wdata & WR_MASK;
        end
    end

    // Expose the register to the read port
    assign rdata = aux_q;

endmodule

// File: rtl/iohn_req_classify.sv
// Request classifier: decides, for one request, whether it raises a
// management-node error event and whether it receives a non-data error.
// Purely combinational; the caller registers the results.
module iohn_req_classify
    import iohn_err_pkg::*;
(
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [TGT_W-1:0]  req_tgt,
    input  logic              cfg_illegal,
    input  logic              err_req_en,
    input  logic              rsperr_maint_en,
    output logic              req_err_evt,
    output logic [CODE_W-1:0] req_code
);
    logic tgt_here;
    logic cache_class;
    logic cfg_bad;

    // Decode target and kind classes
    always_comb begin
        tgt_here    = (req_tgt == T_LOCAL) || (req_tgt == T_MGMT);
        cache_class = (req_kind == K_RD_CACHE) || (req_kind == K_WR_CACHE) ||
                      (req_kind == K_MAINT);
        cfg_bad     = ((req_kind == K_CFG_RD) || (req_kind == K_CFG_WR)) &&
                      (req_tgt == T_MGMT) && cfg_illegal;
    end

    // Event toward the management node
    assign req_err_evt = req_valid && err_req_en && (cache_class || cfg_bad);

    // Response code returned to the requester
    always_comb begin
        req_code = RSP_OK;
        if (tgt_here && (req_kind == K_RD_CACHE)) begin
            req_code = RSP_NDERR;
        end else if (tgt_here && (req_kind == K_MAINT) && rsperr_maint_en) begin
            req_code = RSP_NDERR;
        end
    end

endmodule

// File: rtl/iohn_rsp_path.sv
// Downstream response path: flags write-response errors (combinational
// event) and forwards read-response codes unchanged after one register.
module iohn_rsp_path
    import iohn_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rsp_valid,
    input  logic [CODE_W-1:0] wr_rsp_code,
    input  logic              err_rsp_en,
    input  logic              rd_rsp_valid,
    input  logic [CODE_W-1:0] rd_rsp_code,
    output logic              wr_err_evt,
    output logic              rd_out_valid,
    output logic [CODE_W-1:0] rd_out_code
);
    // Write-response error event when enabled
    assign wr_err_evt = wr_rsp_valid && err_rsp_en && code_is_err(wr_rsp_code);

    // Forward read responses one cycle later without change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out_valid <= 1'b0;
            rd_out_code  <= RSP_OK;
        end else begin
            rd_out_valid <= rd_rsp_valid;
            rd_out_code  <= rd_rsp_valid ? rd_rsp_code : RSP_OK;
        end
    end

endmodule

// File: rtl/iohn_err_steer.sv
// Top: I/O home-node error response steering.
// Combines request classification, downstream response checks and the
// control register; registers the error event and request response.
// Assumes one request and one of each response at most per cycle.
module iohn_err_steer
    import iohn_err_pkg::*;
#(
    parameter int AUX_W        = 16,
    parameter int ERR_REQ_BIT  = 2,
    parameter int ERR_RSP_BIT  = 3,
    parameter int MAINT_BIT    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [1:0]        req_tgt,
    input  logic              cfg_illegal,
    input  logic              wr_rsp_valid,
    input  logic [1:0]        wr_rsp_code,
    input  logic              rd_rsp_valid,
    input  logic [1:0]        rd_rsp_code,
    input  logic              cfg_wr_en,
    input  logic [AUX_W-1:0]  cfg_wdata,
    output logic [AUX_W-1:0]  cfg_rdata,
    output logic              mn_err_pulse,
    output logic              req_rsp_valid,
    output logic [1:0]        req_rsp_code,
    output logic              rd_out_valid,
    output logic [1:0]        rd_out_code
);
    localparam logic [AUX_W-1:0] WR_MASK = (AUX_W'(1) << ERR_REQ_BIT) |
                                           (AUX_W'(1) << ERR_RSP_BIT) |
                                           (AUX_W'(1) << MAINT_BIT);
    localparam logic [AUX_W-1:0] RST_VAL = AUX_W'(1) << ERR_REQ_BIT;

    logic              req_err_evt;
    logic              wr_err_evt;
    logic [CODE_W-1:0] req_code;

    iohn_aux_regs #(
        .AUX_W   (AUX_W),
        .WR_MASK (WR_MASK),
        .RST_VAL (RST_VAL)
    ) u_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata)
    );

    iohn_req_classify u_cls (
        .req_valid       (req_valid),
        .req_kind        (req_kind),
        .req_tgt         (req_tgt),
        .cfg_illegal     (cfg_illegal),
        .err_req_en      (cfg_rdata[ERR_REQ_BIT]),
        .rsperr_maint_en (cfg_rdata[MAINT_BIT]),
        .req_err_evt     (req_err_evt),
        .req_code        (req_code)
    );

    iohn_rsp_path u_rsp (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_rsp_valid (wr_rsp_valid),
        .wr_rsp_code  (wr_rsp_code),
        .err_rsp_en   (cfg_rdata[ERR_RSP_BIT]),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_code  (rd_rsp_code),
        .wr_err_evt   (wr_err_evt),
        .rd_out_valid (rd_out_valid),
        .rd_out_code  (rd_out_code)
    );

    // Register the merged error event and the request response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mn_err_pulse  <= 1'b0;
            req_rsp_valid <= 1'b0;
            req_rsp_code  <= RSP_OK;
        end else begin
            mn_err_pulse  <= req_err_evt | wr_err_evt;
            req_rsp_valid <= req_valid;
            req_rsp_code  <= req_valid ? req_code : RSP_OK;
        end
    end

endmodule

// File: rtl/iohn_err_steer_chk.sv
// Checker for iohn_err_steer, bound to the top. Observes ports only.
module iohn_err_steer_chk #(
    parameter int AUX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic [1:0]       req_tgt,
    input logic             wr_rsp_valid,
    input logic             rd_rsp_valid,
    input logic [1:0]       rd_rsp_code,
    input logic [AUX_W-1:0] cfg_rdata,
    input logic             mn_err_pulse,
    input logic             req_rsp_valid,
    input logic [1:0]       req_rsp_code,
    input logic             rd_out_valid,
    input logic [1:0]       rd_out_code
);
    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~AUX_W'(16'h010C)) == '0);

    // R6
    coh_read_nderr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd2 && (req_tgt == 2'd1 || req_tgt == 2'd2))
        |=> (req_rsp_valid && req_rsp_code == 2'b11));

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> req_rsp_valid);

    // R9
    rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rsp_valid |=> (rd_out_valid && rd_out_code == $past(rd_rsp_code)));

    // R10
    pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !wr_rsp_valid) |=> !mn_err_pulse);

    // R5
    wr_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rsp_valid && !req_valid && !cfg_rdata[3]) |=> !mn_err_pulse);

endmodule

bind iohn_err_steer iohn_err_steer_chk #(.AUX_W(AUX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_tgt       (req_tgt),
    .wr_rsp_valid  (wr_rsp_valid),
    .rd_rsp_valid  (rd_rsp_valid),
    .rd_rsp_code   (rd_rsp_code),
    .cfg_rdata     (cfg_rdata),
    .mn_err_pulse  (mn_err_pulse),
    .req_rsp_valid (req_rsp_valid),
    .req_rsp_code  (req_rsp_code),
    .rd_out_valid  (rd_out_valid),
    .rd_out_code   (rd_out_code)
);

// File: tb/tb_iohn_err_steer.sv
`timescale 1ns/1ps
module tb_iohn_err_steer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [1:0]  req_tgt = '0;
    logic        cfg_illegal = 1'b0;
    logic        wr_rsp_valid = 1'b0;
    logic [1:0]  wr_rsp_code = '0;
    logic        rd_rsp_valid = 1'b0;
    logic [1:0]  rd_rsp_code = '0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        mn_err_pulse;
    logic        req_rsp_valid;
    logic [1:0]  req_rsp_code;
    logic        rd_out_valid;
    logic [1:0]  rd_out_code;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] m_aux;

    always #2.5 clk = ~clk;

    iohn_err_steer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_tgt(req_tgt), .cfg_illegal(cfg_illegal), .wr_rsp_valid(wr_rsp_valid),
        .wr_rsp_code(wr_rsp_code), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_code(rd_rsp_code), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mn_err_pulse(mn_err_pulse),
        .req_rsp_valid(req_rsp_valid), .req_rsp_code(req_rsp_code),
        .rd_out_valid(rd_out_valid), .rd_out_code(rd_out_code)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected event (R3, R4, R5, R10)
    function automatic logic exp_pulse(input logic rv, input logic [2:0] k,
        input logic [1:0] t, input logic ill, input logic wv, input logic [1:0] wc,
        input logic [15:0] aux);
        logic ev_req, ev_wr;
        ev_req = rv && aux[2] && ((k == 3'd2) || (k == 3'd3) || (k == 3'd4) ||
                 (((k == 3'd5) || (k == 3'd6)) && t == 2'd2 && ill));
        ev_wr  = wv && aux[3] && (wc == 2'b10 || wc == 2'b11);
        return ev_req || ev_wr;
    endfunction

    // Expected request response code (R6, R7, R8)
    function automatic logic [1:0] exp_code(input logic rv, input logic [2:0] k,
        input logic [1:0] t, input logic [15:0] aux);
        logic here;
        here = (t == 2'd1) || (t == 2'd2);
        if (!rv) return 2'b00;
        if (here && k == 3'd2) return 2'b11;
        if (here && k == 3'd4 && aux[8]) return 2'b11;
        return 2'b00;
    endfunction

    // Apply one cycle of stimulus, then check registered outputs
    task automatic cycle(input logic rv, input logic [2:0] k, input logic [1:0] t,
        input logic ill, input logic wv, input logic [1:0] wc, input logic dv,
        input logic [1:0] dc, input logic we, input logic [15:0] wd);
        logic ep;
        logic [1:0] ec;
        @(negedge clk);
        req_valid = rv; req_kind = k; req_tgt = t; cfg_illegal = ill;
        wr_rsp_valid = wv; wr_rsp_code = wc; rd_rsp_valid = dv; rd_rsp_code = dc;
        cfg_wr_en = we; cfg_wdata = wd;
        ep = exp_pulse(rv, k, t, ill, wv, wc, m_aux);
        ec = exp_code(rv, k, t, m_aux);
        @(posedge clk);
        #1;
        if (we) m_aux = wd & 16'h010C;
        check("R3/R4/R5/R10 mn_err_pulse", {15'd0, mn_err_pulse}, {15'd0, ep});
        check("R8 req_rsp_valid", {15'd0, req_rsp_valid}, {15'd0, rv});
        check("R6/R7/R8 req_rsp_code", {14'd0, req_rsp_code}, {14'd0, ec});
        check("R9 rd_out_valid", {15'd0, rd_out_valid}, {15'd0, dv});
        if (dv) check("R9 rd_out_code", {14'd0, rd_out_code}, {14'd0, dc});
        check("R1/R2 cfg_rdata", cfg_rdata, m_aux);
        req_valid = 0; wr_rsp_valid = 0; rd_rsp_valid = 0; cfg_wr_en = 0;
    endtask

    task automatic idle();
        cycle(0, 3'd0, 2'd0, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        m_aux = 16'h0004;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 cfg_rdata reset", cfg_rdata, 16'h0004);
        check("R1 mn_err_pulse reset", {15'd0, mn_err_pulse}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R3 cacheable write with default enable
        cycle(1, 3'd3, 2'd0, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        // R5 write error ignored while bit 3 is clear
        cycle(0, 3'd0, 2'd0, 0, 1, 2'b11, 0, 2'b00, 0, 16'h0);
        // R2 write all ones: only bits 2,3,8 stick
        cycle(0, 3'd0, 2'd0, 0, 0, 2'b00, 0, 2'b00, 1, 16'hFFFF);
        check("R2 masked write", cfg_rdata, 16'h010C);
        // R5 write error now signalled; exclusive OK not
        cycle(0, 3'd0, 2'd0, 0, 1, 2'b10, 0, 2'b00, 0, 16'h0);
        cycle(0, 3'd0, 2'd0, 0, 1, 2'b01, 0, 2'b00, 0, 16'h0);
        // R7 maintenance to local node gets non-data error
        cycle(1, 3'd4, 2'd1, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        // R10 simultaneous events then quiet cycle
        cycle(1, 3'd2, 2'd2, 0, 1, 2'b11, 0, 2'b00, 0, 16'h0);
        idle();
        check("R10 pulse drops", {15'd0, mn_err_pulse}, 16'h0);
        // R4 illegal config to management node, legal one, wrong target
        cycle(1, 3'd6, 2'd2, 1, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        cycle(1, 3'd5, 2'd2, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        cycle(1, 3'd5, 2'd1, 1, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        // R9 read errors pass through
        cycle(0, 3'd0, 2'd0, 0, 0, 2'b00, 1, 2'b10, 0, 16'h0);
        cycle(0, 3'd0, 2'd0, 0, 0, 2'b00, 1, 2'b11, 0, 16'h0);
        // Clear everything: R6 still errors, R7 and R3 quiet
        cycle(0, 3'd0, 2'd0, 0, 0, 2'b00, 0, 2'b00, 1, 16'h0000);
        cycle(1, 3'd2, 2'd1, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        cycle(1, 3'd4, 2'd2, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        // R8 plain request to downstream gets OK
        cycle(1, 3'd0, 2'd0, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic we;
            we = ($urandom % 8) == 0;
            cycle($urandom % 2, 3'($urandom), 2'($urandom), $urandom % 2,
                  $urandom % 2, 2'($urandom), $urandom % 2, 2'($urandom),
                  we, 16'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule